// File: doc/BRIEF.md
# Concurrent Core Scan Session Sequencer

This block runs one scan test session in which several wrapped cores are tested at the same time over a shared test access bus. Each core has its own shift length and its own pattern count. A start pulse samples these values. The block then produces, for every core, a test-enable, a scan-enable, a capture window and an unload indication, and it keeps per-core running counts of applied vectors and shift cycles. It raises a done level per core, a single-cycle pulse for the whole session followed by a held done level, and the total number of cycles the session took.

A mode input chooses between two timings. In independent mode every core runs its own loop and stops when its own work is finished, so the session is as long as its slowest core. In lockstep mode the cores run the capture vectors they all share with a common chain length. After that comes one shared unload pass. Each core then finishes its surplus vectors at its own length with no capture. Test clocks, test resets, wrapper cells and pattern storage are outside this block.

Top module: `sts_session_seq`

## Requirements
- R1: After reset every output is low or zero, and it stays that way until a start pulse arrives.
- R2: Each vector is a shift of L cycles with scan-enable high, followed by exactly 5 cycles with capture high. The capture window never overlaps scan-enable. The per-core capture-cycle total is 5 times the number of captured vectors.
- R3: In independent mode, a core with shift length L and pattern count P>0 raises its done level exactly P×(L+5)+L cycles after the start edge. At that point its vector count reads P and its shift count reads P×L+L.
- R4: In independent mode, the session cycle count and the session-done pulse come at the maximum over cores of P×(L+5)+L. With (L,P) = (218,45) and (48,160) this is 10,253.
- R5: In lockstep mode, with Pm the smallest nonzero pattern count and Lm the largest shift length among cores with patterns, core i finishes after Pm×(Lm+5)+Lm+(Pi−Pm)×Li cycles. The session takes the maximum of these. With (218,45) and (48,160) this is 15,773.
- R6: A core with pattern count zero shows done on the first cycle after start, never asserts scan-enable, and reports zero vectors. If every core has zero patterns, the session pulse comes one cycle after start with a cycle count of 0.
- R7: Unload is high on every shift cycle except those loading a core's first vector. Per core, unload cycles therefore equal shift cycles minus the first load length.
- R8: Test-enable for a core is high only while that core is sequencing, and never while the session is idle.
- R9: Session-done is a one-cycle pulse. The done level holds until the next start, and the cycle count stays frozen after the session ends.
- R10: A start pulse during a running session is ignored, and configuration inputs are sampled only at an accepted start. Changes while running do not alter timing or counts.
- R11: A shift length of zero is run as a length of one.
- R12: An accepted start clears the session done level and the cycle count before the new session begins counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Session start request |
| lockstep_i | input | 1 | 1 = lockstep timing, 0 = independent |
| shift_len_i | input | NUM_CORES×LEN_W | Per-core shift length, core 0 in the low slice |
| pat_cnt_i | input | NUM_CORES×CNT_W | Per-core pattern count, core 0 in the low slice |
| test_en_o | output | NUM_CORES | Per-core test enable |
| scan_en_o | output | NUM_CORES | Per-core scan-enable |
| capture_o | output | NUM_CORES | Per-core apply/capture window |
| unload_o | output | NUM_CORES | Per-core response unload in progress |
| core_done_o | output | NUM_CORES | Per-core done level |
| vec_cnt_o | output | NUM_CORES×CNT_W | Per-core vectors completed |
| shift_cnt_o | output | NUM_CORES×CYC_W | Per-core shift cycles so far |
| busy_o | output | 1 | Session running |
| sess_done_pulse_o | output | 1 | One-cycle session end pulse |
| sess_done_o | output | 1 | Held session done level |
| sess_cycles_o | output | CYC_W | Session cycle count |

## Verification
On every cycle, the assertions check the shape of each capture window and that capture follows a shift. They check that a zero-pattern core stays out of scan and that a core's vector count matches its pattern total when it finishes. They also check that the session pulse is a single cycle, that it comes only when all cores are done, that test-enable stays quiet while the session is idle, and that the counter does not move after the session ends. Only the bench's scenarios can show the exact finishing cycles from the two timing formulas, the per-core shift and unload totals, the rule that a zero shift length runs as one, and the ignoring of a start and a configuration change in the middle of a session.

// File: rtl/sts_pkg.sv
package sts_pkg;

  // fixed apply/capture overhead per captured vector
  localparam int unsigned OVH_CYCLES = 5;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_SHIFT,
    EN_APPLY,
    EN_UNLD,
    EN_TAIL,
    EN_DONE
  } eng_state_e;

  // a zero shift length is run as one cycle
  function automatic int unsigned eff_len(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  // cycles one core needs when it runs on its own
  function automatic int unsigned indep_cycles(input int unsigned len, input int unsigned pats);
    return (pats == 0) ? 0 : pats * (eff_len(len) + OVH_CYCLES) + eff_len(len);
  endfunction

  // cycles one core needs in lockstep given the shared minimum count and maximum length
  function automatic int unsigned lock_cycles(input int unsigned len, input int unsigned pats,
                                              input int unsigned pmin, input int unsigned lmax);
    return (pats == 0) ? 0 :
           pmin * (lmax + OVH_CYCLES) + lmax + (pats - pmin) * eff_len(len);
  endfunction

endpackage

// File: rtl/sts_cfg_plan.sv
module sts_cfg_plan
  import sts_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                       lockstep_i,
  input  logic [NUM_CORES*LEN_W-1:0] len_i,
  input  logic [NUM_CORES*CNT_W-1:0] pat_i,
  output logic [NUM_CORES*CNT_W-1:0] n1_o,
  output logic [NUM_CORES*CNT_W-1:0] n2_o,
  output logic [NUM_CORES*LEN_W-1:0] s1_o,
  output logic [NUM_CORES*LEN_W-1:0] s2_o
);

  logic [CNT_W-1:0] pmin;
  logic [LEN_W-1:0] lmax;

  // shared lockstep parameters over cores that carry patterns
  always_comb begin
    pmin = '1;
    lmax = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (pat_i[i*CNT_W +: CNT_W] != '0) begin
        if (pat_i[i*CNT_W +: CNT_W] < pmin) pmin = pat_i[i*CNT_W +: CNT_W];
        if (LEN_W'(eff_len(32'(len_i[i*LEN_W +: LEN_W]))) > lmax)
          lmax = LEN_W'(eff_len(32'(len_i[i*LEN_W +: LEN_W])));
      end
    end
  end

  // per-core plan: n1 captured vectors of length s1, one unload of s1, n2 tail vectors of s2
  always_comb begin
    n1_o = '0;
    n2_o = '0;
    s1_o = '0;
    s2_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      s2_o[i*LEN_W +: LEN_W] = LEN_W'(eff_len(32'(len_i[i*LEN_W +: LEN_W])));
      if (!lockstep_i) begin
        n1_o[i*CNT_W +: CNT_W] = pat_i[i*CNT_W +: CNT_W];
        s1_o[i*LEN_W +: LEN_W] = LEN_W'(eff_len(32'(len_i[i*LEN_W +: LEN_W])));
      end else if (pat_i[i*CNT_W +: CNT_W] != '0) begin
        n1_o[i*CNT_W +: CNT_W] = pmin;
        n2_o[i*CNT_W +: CNT_W] = pat_i[i*CNT_W +: CNT_W] - pmin;
        s1_o[i*LEN_W +: LEN_W] = lmax;
      end else begin
        s1_o[i*LEN_W +: LEN_W] = lmax;
      end
    end
  end

endmodule

// File: rtl/sts_core_engine.sv
module sts_core_engine
  import sts_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CYC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] n1_i,
  input  logic [CNT_W-1:0] n2_i,
  input  logic [LEN_W-1:0] s1_i,
  input  logic [LEN_W-1:0] s2_i,
  output logic             active_o,
  output logic             last_o,
  output logic             done_o,
  output logic             test_en_o,
  output logic             scan_en_o,
  output logic             capture_o,
  output logic             unload_o,
  output logic [CNT_W-1:0] vec_cnt_o,
  output logic [CYC_W-1:0] shift_cnt_o
);

  localparam logic [LEN_W-1:0] OVH_LAST = LEN_W'(OVH_CYCLES - 1);

  eng_state_e       state_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] s1_q, s2_q;
  logic [CNT_W-1:0] n1_left_q, n2_left_q;
  logic [CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] vec_q;
  logic [CYC_W-1:0] shc_q;
  logic             loaded_q;

  // named phase events
  logic phase_end, last_capture, last_tail;
  assign phase_end    = (rem_q == '0);
  assign last_capture = (n1_left_q == CNT_W'(1));
  assign last_tail    = (n2_left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= EN_IDLE;
      rem_q     <= '0;
      s1_q      <= '0;
      s2_q      <= '0;
      n1_left_q <= '0;
      n2_left_q <= '0;
      tot_q     <= '0;
      vec_q     <= '0;
      shc_q     <= '0;
      loaded_q  <= 1'b0;
    end else if (load_i) begin
      s1_q      <= s1_i;
      s2_q      <= s2_i;
      n1_left_q <= n1_i;
      n2_left_q <= n2_i;
      tot_q     <= n1_i + n2_i;
      vec_q     <= '0;
      shc_q     <= '0;
      loaded_q  <= 1'b0;
      rem_q     <= s1_i - LEN_W'(1);
      state_q   <= (n1_i == '0) ? EN_DONE : EN_SHIFT;
    end else begin
      if (scan_en_o) shc_q <= shc_q + CYC_W'(1);
      unique case (state_q)
        EN_SHIFT: begin
          if (phase_end) begin
            state_q <= EN_APPLY;
            rem_q   <= OVH_LAST;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
          end
        end
        EN_APPLY: begin
          if (phase_end) begin
            vec_q     <= vec_q + CNT_W'(1);
            loaded_q  <= 1'b1;
            n1_left_q <= n1_left_q - CNT_W'(1);
            rem_q     <= s1_q - LEN_W'(1);
            state_q   <= last_capture ? EN_UNLD : EN_SHIFT;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
          end
        end
        EN_UNLD: begin
          if (phase_end) begin
            rem_q   <= s2_q - LEN_W'(1);
            state_q <= (n2_left_q == '0) ? EN_DONE : EN_TAIL;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
          end
        end
        EN_TAIL: begin
          if (phase_end) begin
            vec_q     <= vec_q + CNT_W'(1);
            n2_left_q <= n2_left_q - CNT_W'(1);
            rem_q     <= s2_q - LEN_W'(1);
            if (last_tail) state_q <= EN_DONE;
          end else begin
            rem_q <= rem_q - LEN_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign active_o    = (state_q != EN_IDLE) && (state_q != EN_DONE);
  assign done_o      = (state_q == EN_DONE);
  assign last_o      = phase_end && (((state_q == EN_UNLD) && (n2_left_q == '0)) ||
                                     ((state_q == EN_TAIL) && last_tail));
  assign test_en_o   = active_o;
  assign scan_en_o   = (state_q == EN_SHIFT) || (state_q == EN_UNLD) || (state_q == EN_TAIL);
  assign capture_o   = (state_q == EN_APPLY);
  assign unload_o    = (state_q == EN_UNLD) || (state_q == EN_TAIL) ||
                       ((state_q == EN_SHIFT) && loaded_q);
  assign vec_cnt_o   = vec_q;
  assign shift_cnt_o = shc_q;

  AST_CAPTURE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(capture_o) |-> ($past(capture_o, 1) && $past(capture_o, 5))); // R2
  AST_SHIFT_BEFORE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(capture_o) |-> $past(scan_en_o)); // R2
  AST_VECTORS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (vec_cnt_o == tot_q)); // R3
  AST_ZERO_PATTERN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_q == '0) |-> !scan_en_o); // R6

endmodule

// File: rtl/sts_session_ctl.sv
module sts_session_ctl #(
  parameter int unsigned CYC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             any_active_i,
  input  logic             all_fin_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_pulse_o,
  output logic             done_o,
  output logic [CYC_W-1:0] cycles_o
);

  logic             busy_q, pulse_q, done_q;
  logic [CYC_W-1:0] cyc_q;
  logic             finish;

  assign load_o = start_i && !busy_q;
  assign finish = busy_q && all_fin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
      cyc_q   <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cyc_q  <= '0;
      end else if (busy_q) begin
        if (any_active_i) cyc_q <= cyc_q + CYC_W'(1);
        if (finish) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          pulse_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_pulse_o = pulse_q;
  assign done_o       = done_q;
  assign cycles_o     = cyc_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |=> !done_pulse_o); // R9
  AST_PULSE_WITH_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |-> done_o); // R9
  AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(cycles_o)); // R9
  AST_START_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (cycles_o >= $past(cycles_o))); // R10

endmodule

// File: rtl/sts_session_seq.sv
module sts_session_seq
  import sts_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CYC_W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       lockstep_i,
  input  logic [NUM_CORES*LEN_W-1:0] shift_len_i,
  input  logic [NUM_CORES*CNT_W-1:0] pat_cnt_i,
  output logic [NUM_CORES-1:0]       test_en_o,
  output logic [NUM_CORES-1:0]       scan_en_o,
  output logic [NUM_CORES-1:0]       capture_o,
  output logic [NUM_CORES-1:0]       unload_o,
  output logic [NUM_CORES-1:0]       core_done_o,
  output logic [NUM_CORES*CNT_W-1:0] vec_cnt_o,
  output logic [NUM_CORES*CYC_W-1:0] shift_cnt_o,
  output logic                       busy_o,
  output logic                       sess_done_pulse_o,
  output logic                       sess_done_o,
  output logic [CYC_W-1:0]           sess_cycles_o
);

  localparam int unsigned LB = NUM_CORES * LEN_W;
  localparam int unsigned CB = NUM_CORES * CNT_W;

  logic [CB-1:0]        n1, n2;
  logic [LB-1:0]        s1, s2;
  logic                 load;
  logic [NUM_CORES-1:0] active, last, done;
  logic                 any_active, all_fin;

  sts_cfg_plan #(
    .NUM_CORES(NUM_CORES), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_plan (
    .lockstep_i(lockstep_i),
    .len_i     (shift_len_i),
    .pat_i     (pat_cnt_i),
    .n1_o      (n1),
    .n2_o      (n2),
    .s1_o      (s1),
    .s2_o      (s2)
  );

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
      sts_core_engine #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .CYC_W(CYC_W)
      ) u_eng (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .n1_i       (n1[g*CNT_W +: CNT_W]),
        .n2_i       (n2[g*CNT_W +: CNT_W]),
        .s1_i       (s1[g*LEN_W +: LEN_W]),
        .s2_i       (s2[g*LEN_W +: LEN_W]),
        .active_o   (active[g]),
        .last_o     (last[g]),
        .done_o     (done[g]),
        .test_en_o  (test_en_o[g]),
        .scan_en_o  (scan_en_o[g]),
        .capture_o  (capture_o[g]),
        .unload_o   (unload_o[g]),
        .vec_cnt_o  (vec_cnt_o[g*CNT_W +: CNT_W]),
        .shift_cnt_o(shift_cnt_o[g*CYC_W +: CYC_W])
      );
    end
  endgenerate

  assign any_active  = |active;
  assign all_fin     = &(done | last);
  assign core_done_o = done;

  sts_session_ctl #(
    .CYC_W(CYC_W)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .any_active_i(any_active),
    .all_fin_i   (all_fin),
    .load_o      (load),
    .busy_o      (busy_o),
    .done_pulse_o(sess_done_pulse_o),
    .done_o      (sess_done_o),
    .cycles_o    (sess_cycles_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (test_en_o == '0)); // R8
  AST_ALL_CORES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_done_pulse_o |-> (&core_done_o)); // R4

endmodule

// File: tb/test_sts_session_seq.sv
`timescale 1ns/1ps
module test_sts_session_seq;
  localparam int unsigned NC = 2, LW = 16, CW = 16, YW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lock = 1'b0;
  logic [NC*LW-1:0] len_bus = '0;
  logic [NC*CW-1:0] pat_bus = '0;
  logic [NC-1:0]    test_en, scan_en, capture, unload, core_done;
  logic [NC*CW-1:0] vec_cnt;
  logic [NC*YW-1:0] shift_cnt;
  logic             busy, pulse, sdone;
  logic [YW-1:0]    scyc;

  int n_tests = 0, n_fail = 0;
  int unsigned wd = 0;

  always #4 clk = ~clk;

  sts_session_seq #(.NUM_CORES(NC), .LEN_W(LW), .CNT_W(CW), .CYC_W(YW)) i_sts_session_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lockstep_i(lock),
    .shift_len_i(len_bus), .pat_cnt_i(pat_bus),
    .test_en_o(test_en), .scan_en_o(scan_en), .capture_o(capture), .unload_o(unload),
    .core_done_o(core_done), .vec_cnt_o(vec_cnt), .shift_cnt_o(shift_cnt),
    .busy_o(busy), .sess_done_pulse_o(pulse), .sess_done_o(sdone), .sess_cycles_o(scyc)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 190000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // stimulus table: lockstep, L0, P0, L1, P1, expected session cycles
  localparam logic [96:0] VEC_TBL [0:6] = '{
    {1'b0, 16'd218, 16'd45, 16'd48, 16'd160, 32'd10253},
    {1'b1, 16'd218, 16'd45, 16'd48, 16'd160, 32'd15773},
    {1'b0, 16'd1,   16'd1,  16'd4,  16'd3,   32'd31},
    {1'b1, 16'd4,   16'd3,  16'd1,  16'd1,   32'd21},
    {1'b0, 16'd5,   16'd0,  16'd2,  16'd2,   32'd16},
    {1'b1, 16'd5,   16'd0,  16'd3,  16'd2,   32'd19},
    {1'b0, 16'd0,   16'd2,  16'd2,  16'd1,   32'd13}
  };

  function automatic int unsigned blen(input int unsigned l);
    return (l == 0) ? 1 : l;
  endfunction

  // bench restatement of the timing rules
  task automatic model(input bit lk, input int unsigned l[NC], input int unsigned p[NC],
                       output int unsigned t[NC], output int unsigned sh[NC],
                       output int unsigned cp[NC], output int unsigned ul[NC]);
    int unsigned pm = 32'hFFFF_FFFF, lm = 0;
    for (int i = 0; i < NC; i++)
      if (p[i] != 0) begin
        if (p[i] < pm) pm = p[i];
        if (blen(l[i]) > lm) lm = blen(l[i]);
      end
    for (int i = 0; i < NC; i++) begin
      int unsigned bl = blen(l[i]);
      if (p[i] == 0) begin
        t[i] = 0; sh[i] = 0; cp[i] = 0; ul[i] = 0;
      end else if (!lk) begin
        t[i] = p[i] * (bl + 5) + bl; sh[i] = p[i] * bl + bl; cp[i] = 5 * p[i]; ul[i] = sh[i] - bl;
      end else begin
        sh[i] = pm * lm + lm + (p[i] - pm) * bl;
        t[i]  = pm * (lm + 5) + lm + (p[i] - pm) * bl;
        cp[i] = 5 * pm; ul[i] = sh[i] - lm;
      end
    end
  endtask

  task automatic run_session(input bit lk, input int unsigned l0, input int unsigned p0,
                             input int unsigned l1, input int unsigned p1,
                             input int unsigned exp_sess, input bit disturb);
    int unsigned l[NC], p[NC], t[NC], sh[NC], cp[NC], ul[NC];
    int done_at[NC], se_c[NC], cp_c[NC], ul_c[NC];
    int pulse_at = -1, j = 0, overlap = 0;
    int unsigned tmax = 0;
    logic [YW-1:0] frozen;
    l[0] = l0; l[1] = l1; p[0] = p0; p[1] = p1;
    model(lk, l, p, t, sh, cp, ul);
    for (int i = 0; i < NC; i++) begin
      done_at[i] = -1; se_c[i] = 0; cp_c[i] = 0; ul_c[i] = 0;
      if (t[i] > tmax) tmax = t[i];
    end
    @(negedge clk);
    lock = lk; len_bus = {LW'(l1), LW'(l0)}; pat_bus = {CW'(p1), CW'(p0)}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12", "count cleared at start", scyc, 0);
    chk("R12", "done level cleared at start", sdone, 0);
    while (pulse_at < 0 && j < 60000) begin
      if (disturb && j == 5) begin
        start = 1'b1; lock = ~lk; len_bus = {LW'(9), LW'(11)}; pat_bus = {CW'(7), CW'(6)};
      end
      if (disturb && j == 6) start = 1'b0;
      for (int i = 0; i < NC; i++) begin
        if (core_done[i] && done_at[i] < 0) done_at[i] = j;
        if (scan_en[i]) se_c[i]++;
        if (capture[i]) cp_c[i]++;
        if (unload[i]) ul_c[i]++;
        if (scan_en[i] && capture[i]) overlap++;
      end
      if (pulse) pulse_at = j;
      @(negedge clk);
      j++;
    end
    chk(lk ? "R5" : "R4", "session cycles", scyc, exp_sess);
    chk(lk ? "R5" : "R4", "model agrees with table", tmax, exp_sess);
    chk(p0 + p1 == 0 ? "R6" : (lk ? "R5" : "R4"), "session pulse cycle", pulse_at,
        (exp_sess == 0) ? 1 : exp_sess);
    chk("R2", "scan/capture overlap cycles", overlap, 0);
    if (disturb) chk("R10", "session cycles after mid-run start", scyc, exp_sess);
    for (int i = 0; i < NC; i++) begin
      string rq;
      rq = (p[i] == 0) ? "R6" : (l[i] == 0) ? "R11" : (lk ? "R5" : "R3");
      chk(rq, $sformatf("core%0d done cycle", i), done_at[i], t[i]);
      chk(disturb ? "R10" : "R3", $sformatf("core%0d vectors", i), vec_cnt[i*CW +: CW], p[i]);
      chk(rq, $sformatf("core%0d shift count", i), shift_cnt[i*YW +: YW], sh[i]);
      chk(rq, $sformatf("core%0d scan-enable cycles", i), se_c[i], sh[i]);
      chk("R2", $sformatf("core%0d capture cycles", i), cp_c[i], cp[i]);
      chk("R7", $sformatf("core%0d unload cycles", i), ul_c[i], ul[i]);
    end
    chk("R9", "pulse one cycle", pulse, 0);
    chk("R9", "done level held", sdone, 1);
    frozen = scyc;
    repeat (3) @(negedge clk);
    chk("R9", "count frozen", scyc, frozen);
    chk("R8", "test enables idle", test_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "scan enables in reset", scan_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "core done after reset", core_done, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "session done after reset", sdone, 0);
    chk("R1", "session count after reset", scyc, 0);
    chk("R1", "test enables after reset", test_en, 0);
    for (int k = 0; k < 7; k++) begin
      logic [96:0] v;
      v = VEC_TBL[k];
      run_session(v[96], v[95:80], v[79:64], v[63:48], v[47:32], v[31:0], 1'b0);
    end
    // start and configuration change mid-session: R10
    run_session(1'b0, 4, 2, 3, 3, 27, 1'b1);
    // every core without patterns: R6
    run_session(1'b0, 3, 0, 2, 0, 0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule